// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block turns bus write cycles into commands for a word-organised flash array. It follows the multi-cycle unlock handshakes, starts program and erase operations, and decides what a bus read returns: array contents, identification codes, or operation status while work is in progress. A small on-chip array stands in for the storage cells. A busy timer, together with an erase sweep of one word per clock, stands in for the real program and erase durations.

A write cycle is one clock in which chip-enable and write-enable are low and output-enable is high. A read cycle is one clock in which chip-enable and output-enable are low and write-enable is high. The read result is registered. A bypass mode lets a host program words with two write cycles instead of four. The synchronous reset acts as the hardware reset. It aborts any program or erase at once and puts the sequencer back in array-read mode. The array contents are not cleared by reset.

Top module: `flashcmd_ctrl`

## Requirements
- R1: While reset is high and in the clock after it is released, `busy` and `rvalid` are 0. The controller starts in array-read mode, so reads return array words with no command.
- R2: Only a clock with `ce_n`=0, `we_n`=0 and `oe_n`=1 counts as a write cycle. A clock with `oe_n`=0 or `ce_n`=1 does not advance a command sequence.
- R3: A program takes four writes: 0xAA at word address 0x555, 0x55 at 0x2AA, 0xA0 at any address, then the data at its target address. `busy` is high for exactly BUSY_CYC clocks. The stored word becomes the old word ANDed with the data.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x20 enter bypass mode. In bypass mode, 0xA0 followed by the data programs a word. The writes 0x90 then 0x00 leave bypass mode, after which 0xA0 plus data no longer programs.
- R5: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 enter ID mode. In ID mode, reads return MFR_ID in bits 7:0 at addr[1:0]=0, DEV_ID at addr[1:0]=1, and zero elsewhere, with bits 15:8 zero. Any write returns the controller to array read.
- R6: Sector erase is 0xAA@0x555, 0x55@0x2AA, 0x80, 0xAA@0x555, 0x55@0x2AA, then 0x30 at an address inside the sector. The sector is addr[ADDR_W-1:ADDR_W-SECT_W]. Each further 0x30 written within ERASE_WIN clocks of the previous one adds its sector. Every word of the chosen sectors becomes all ones, and other sectors keep their contents.
- R7: Chip erase uses the same five lead-in writes followed by 0x10@0x555. It sets every word to all ones.
- R8: A read cycle while `busy` is high returns status. Bit 7 is the complement of bit 7 of the written data (data is all ones for an erase). Bit 6 is 0 on the first status read of an operation and flips on each further status read. All other bits are 0.
- R9: A write that does not match the next expected cycle of a sequence returns the controller to array read, and the partial sequence is dropped.
- R10: Asserting reset during a program or erase ends it. `busy` is low after the reset, the word being programmed keeps its old value, and the controller is in array read.
- R11: A read cycle yields `rdata` with `rvalid`=1 in the following clock. `rvalid` is 0 after a clock without a read cycle.
- R12: Writes made while a program is busy are ignored and leave no partial sequence behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts as the hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; commands are taken from bits 7:0 |
| rdata | output | DATA_W | Read data: array word, ID code or status |
| rvalid | output | 1 | `rdata` holds the result of the previous clock's read cycle |
| busy | output | 1 | A program or erase is in progress |

## Verification
A read result appears in the clock after its read cycle. The bench driver queues each expected word when it issues the read, and the monitor pops and compares one word on every falling edge where `rvalid` is high. `busy` rises in the clock after the last write of a command and stays high for BUSY_CYC clocks for a program, or ERASE_WIN plus the array depth for an erase. The bench counts busy falling edges to check the program length and waits for `busy` to drop before it reads back stored words. Status reads are issued back to back directly after the final write, so their toggle sequence falls inside the busy window.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  typedef enum logic [3:0] {
    SQ_READ, SQ_UNL1, SQ_UNL2, SQ_PDATA, SQ_IDMODE,
    SQ_ERS3, SQ_ERS4, SQ_ERS5, SQ_ERSMORE, SQ_OPWAIT,
    SQ_BYP, SQ_BYPDATA, SQ_BYPEXIT
  } seq_t;

  typedef enum logic [1:0] {EN_IDLE, EN_PROG, EN_WIN, EN_SWEEP} eng_t;

  localparam logic [7:0] K_UNL1  = 8'hAA;
  localparam logic [7:0] K_UNL2  = 8'h55;
  localparam logic [7:0] K_PROG  = 8'hA0;
  localparam logic [7:0] K_ERASE = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_ID    = 8'h90;
  localparam logic [7:0] K_BYPIN = 8'h20;
  localparam logic [7:0] K_BYPX  = 8'h00;
  localparam logic [11:0] A_FIRST  = 12'h555;
  localparam logic [11:0] A_SECOND = 12'h2AA;
endpackage

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  input  logic              op_done,
  output logic              id_mode,
  output logic              go_prog,
  output logic              go_sect,
  output logic              go_chip
);
  localparam logic [ADDR_W-1:0] AF = ADDR_W'(A_FIRST);
  localparam logic [ADDR_W-1:0] AS = ADDR_W'(A_SECOND);

  seq_t st, nxt;
  logic byp, byp_n;
  logic first_ok, second_ok;

  assign first_ok  = (addr == AF) && (cmd == K_UNL1);
  assign second_ok = (addr == AS) && (cmd == K_UNL2);
  assign id_mode   = (st == SQ_IDMODE);

  always_comb begin
    nxt = st;
    go_prog = 1'b0;
    go_sect = 1'b0;
    go_chip = 1'b0;
    if (wr_stb) begin
      case (st)
        SQ_READ:   nxt = first_ok  ? SQ_UNL1 : SQ_READ;
        SQ_UNL1:   nxt = second_ok ? SQ_UNL2 : SQ_READ;
        SQ_UNL2: begin
          case (cmd)
            K_PROG:  nxt = SQ_PDATA;
            K_ID:    nxt = (addr == AF) ? SQ_IDMODE : SQ_READ;
            K_ERASE: nxt = SQ_ERS3;
            K_BYPIN: nxt = SQ_BYP;
            default: nxt = SQ_READ;
          endcase
        end
        SQ_PDATA: begin
          go_prog = 1'b1;
          nxt = SQ_OPWAIT;
        end
        SQ_IDMODE: nxt = SQ_READ;
        SQ_ERS3:   nxt = first_ok  ? SQ_ERS4 : SQ_READ;
        SQ_ERS4:   nxt = second_ok ? SQ_ERS5 : SQ_READ;
        SQ_ERS5: begin
          if (cmd == K_SECT) begin
            go_sect = 1'b1;
            nxt = SQ_ERSMORE;
          end else if (cmd == K_CHIP && addr == AF) begin
            go_chip = 1'b1;
            nxt = SQ_OPWAIT;
          end else begin
            nxt = SQ_READ;
          end
        end
        SQ_ERSMORE: go_sect = (cmd == K_SECT);
        SQ_OPWAIT:  nxt = SQ_OPWAIT;
        SQ_BYP: begin
          case (cmd)
            K_PROG:  nxt = SQ_BYPDATA;
            K_ID:    nxt = SQ_BYPEXIT;
            default: nxt = SQ_READ;
          endcase
        end
        SQ_BYPDATA: begin
          go_prog = 1'b1;
          nxt = SQ_OPWAIT;
        end
        SQ_BYPEXIT: nxt = SQ_READ;
        default:    nxt = SQ_READ;
      endcase
    end
    if ((st == SQ_OPWAIT || st == SQ_ERSMORE) && op_done)
      nxt = byp ? SQ_BYP : SQ_READ;
  end

  always_comb begin
    byp_n = byp;
    if (nxt == SQ_BYP || nxt == SQ_BYPDATA || nxt == SQ_BYPEXIT) byp_n = 1'b1;
    else if (nxt == SQ_READ) byp_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_READ;
      byp <= 1'b0;
    end else begin
      st  <= nxt;
      byp <= byp_n;
    end
  end
endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int BUSY_CYC  = 8,
  parameter int ERASE_WIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_sect,
  input  logic              go_chip,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mem_q,
  output logic              busy,
  output logic              op_start,
  output logic              op_done,
  output logic              stat_d7,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSECT = 1 << SECT_W;
  localparam int CW    = $clog2(DEPTH + BUSY_CYC + ERASE_WIN) + 1;
  localparam logic [CW-1:0] P_LAST = CW'(BUSY_CYC - 1);
  localparam logic [CW-1:0] W_LAST = CW'(ERASE_WIN - 1);
  localparam logic [CW-1:0] S_LAST = CW'(DEPTH - 1);

  eng_t st;
  logic [CW-1:0]     cnt;
  logic [NSECT-1:0]  mask;
  logic [ADDR_W-1:0] pa;
  logic [DATA_W-1:0] pd;
  logic [ADDR_W-1:0] sweep_a;
  logic [SECT_W-1:0] new_sect;

  assign sweep_a  = cnt[ADDR_W-1:0];
  assign new_sect = addr[ADDR_W-1 -: SECT_W];
  assign busy     = (st != EN_IDLE);
  assign op_start = (st == EN_IDLE) && (go_prog || go_sect || go_chip);
  assign op_done  = (st == EN_PROG && cnt == P_LAST) ||
                    (st == EN_SWEEP && cnt == S_LAST);

  assign ram_raddr = pa;
  assign ram_we    = (st == EN_PROG && cnt == P_LAST) ||
                     (st == EN_SWEEP && mask[sweep_a[ADDR_W-1 -: SECT_W]]);
  assign ram_waddr = (st == EN_SWEEP) ? sweep_a : pa;
  assign ram_wdata = (st == EN_SWEEP) ? {DATA_W{1'b1}} : (mem_q & pd);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= EN_IDLE;
      cnt     <= '0;
      mask    <= '0;
      pa      <= '0;
      pd      <= '0;
      stat_d7 <= 1'b1;
    end else begin
      case (st)
        EN_IDLE: begin
          cnt <= '0;
          if (go_prog) begin
            st      <= EN_PROG;
            pa      <= addr;
            pd      <= wdata;
            stat_d7 <= wdata[7];
          end else if (go_chip) begin
            st      <= EN_WIN;
            mask    <= '1;
            stat_d7 <= 1'b1;
          end else if (go_sect) begin
            st      <= EN_WIN;
            mask    <= NSECT'(1) << new_sect;
            stat_d7 <= 1'b1;
          end
        end
        EN_PROG: begin
          cnt <= cnt + 1'b1;
          if (cnt == P_LAST) st <= EN_IDLE;
        end
        EN_WIN: begin
          if (go_sect) begin
            mask <= mask | (NSECT'(1) << new_sect);
            cnt  <= '0;
          end else if (cnt == W_LAST) begin
            st  <= EN_SWEEP;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        EN_SWEEP: begin
          cnt <= cnt + 1'b1;
          if (cnt == S_LAST) st <= EN_IDLE;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flashcmd_ram.sv
module flashcmd_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl #(
  parameter int         ADDR_W    = 11,
  parameter int         DATA_W    = 16,
  parameter int         SECT_W    = 2,
  parameter int         BUSY_CYC  = 8,
  parameter int         ERASE_WIN = 16,
  parameter logic [7:0] MFR_ID    = 8'h5A,
  parameter logic [7:0] DEV_ID    = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              busy
);
  logic wr_stb, rd_stb;
  logic id_mode, go_prog, go_sect, go_chip;
  logic op_start, op_done, stat_d7;
  logic ram_we;
  logic [ADDR_W-1:0] eng_raddr, ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, mem_q;
  logic [DATA_W-1:0] side_q, status_w, id_w;
  logic src_side, tog;

  assign wr_stb = !ce_n && !we_n && oe_n;
  assign rd_stb = !ce_n && !oe_n && we_n;

  flashcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .cmd(wdata[7:0]),
    .op_done(op_done), .id_mode(id_mode),
    .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip)
  );

  flashcmd_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .BUSY_CYC(BUSY_CYC), .ERASE_WIN(ERASE_WIN)
  ) u_eng (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_sect(go_sect),
    .go_chip(go_chip), .addr(addr), .wdata(wdata), .mem_q(mem_q),
    .busy(busy), .op_start(op_start), .op_done(op_done), .stat_d7(stat_d7),
    .ram_raddr(eng_raddr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata)
  );

  assign ram_raddr = busy ? eng_raddr : addr;

  flashcmd_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .q(mem_q)
  );

  always_comb begin
    status_w    = '0;
    status_w[7] = ~stat_d7;
    status_w[6] = tog;
    id_w        = '0;
    case (addr[1:0])
      2'd0:    id_w[7:0] = MFR_ID;
      2'd1:    id_w[7:0] = DEV_ID;
      default: id_w[7:0] = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid   <= 1'b0;
      src_side <= 1'b0;
      side_q   <= '0;
      tog      <= 1'b0;
    end else begin
      rvalid <= rd_stb;
      if (op_start) tog <= 1'b0;
      else if (rd_stb && busy) tog <= ~tog;
      if (rd_stb) begin
        src_side <= busy || id_mode;
        side_q   <= busy ? status_w : id_w;
      end
    end
  end

  assign rdata = src_side ? side_q : mem_q;
endmodule

module flashcmd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              busy,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata
);
  logic rd_c, wr_c;
  assign rd_c = !ce_n && !oe_n && we_n;
  assign wr_c = !ce_n && !we_n && oe_n;

  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> (!busy && !rvalid));
  a_r11_read_result_due: assert property (@(posedge clk) disable iff (rst) rd_c |=> rvalid);
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst) !rd_c |=> !rvalid);
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(wr_c));
  a_r8_status_fields: assert property (@(posedge clk) disable iff (rst)
    (rd_c && busy) |=> (rdata[DATA_W-1:8] == '0 && rdata[5:0] == '0));
  a_r8_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (rd_c && busy) ##1 (rd_c && busy) |=> (rdata[6] != $past(rdata[6])));
endmodule

bind flashcmd_ctrl flashcmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .rvalid(rvalid), .rdata(rdata)
);

// File: tb/tb_flashcmd_ctrl.sv
module tb_flashcmd_ctrl;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int BC = 8;
  localparam int EW = 16;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hC3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, ce_n, oe_n, we_n, rvalid, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int n_chk = 0, n_fail = 0, bcnt = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  flashcmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(2), .BUSY_CYC(BC),
    .ERASE_WIN(EW), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy));

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 16'h1, 16'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic wr_bad(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit oe_low);
    ce_n = oe_low ? 1'b0 : 1'b1; we_n = 0; oe_n = oe_low ? 1'b0 : 1'b1;
    addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic unl;
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic erase_lead;
    unl; wr(11'h555, 16'h0080); unl;
  endtask

  initial begin
    rst = 1; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    check("R1 busy in reset", {15'd0, busy}, 16'h0);
    rst = 0;
    @(negedge clk);
    check("R1 busy after reset", {15'd0, busy}, 16'h0);
    check("R1 rvalid after reset", {15'd0, rvalid}, 16'h0);

    // R7 chip erase
    erase_lead; wr(11'h555, 16'h0010);
    check("R7 busy after chip erase", {15'd0, busy}, 16'h1);
    wait_idle;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    rd(11'h000, 16'hFFFF, "R7 word 0"); rd(11'h7FF, 16'hFFFF, "R7 last word");
    rd(11'h400, 16'hFFFF, "R7 mid word");

    // R3 program + R8 status
    unl; wr(11'h555, 16'h00A0); bcnt = 0; wr(11'h012, 16'h5A3C);
    rd(11'h012, 16'h0080, "R8 status 1"); rd(11'h012, 16'h00C0, "R8 status 2");
    rd(11'h012, 16'h0080, "R8 status 3");
    wait_idle;
    check("R3 busy length", 16'(bcnt), 16'(BC));
    model[11'h012] = 16'h5A3C;
    rd(11'h012, 16'h5A3C, "R3 programmed");
    unl; wr(11'h555, 16'h00A0); wr(11'h012, 16'h0FF0); wait_idle;
    model[11'h012] = 16'h0A30;
    rd(11'h012, 16'h0A30, "R3 AND of old and new");

    // R2 invalid write cycles
    wr_bad(11'h555, 16'h00AA, 1'b1); wr(11'h2AA, 16'h0055);
    wr(11'h555, 16'h00A0); wr(11'h020, 16'h0000);
    check("R2 no busy after oe-low write", {15'd0, busy}, 16'h0);
    unl; wr_bad(11'h555, 16'h00A0, 1'b0); wr(11'h020, 16'h0000);
    check("R2 no busy after ce-high write", {15'd0, busy}, 16'h0);
    rd(11'h020, 16'hFFFF, "R2 word untouched");

    // R9 mismatch
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'h021, 16'h0000);
    check("R9 no busy after bad unlock", {15'd0, busy}, 16'h0);
    rd(11'h021, 16'hFFFF, "R9 word untouched");
    unl; wr(11'h555, 16'h00A0); wr(11'h021, 16'h1234); wait_idle;
    rd(11'h021, 16'h1234, "R9 recovery to array read");

    // R5 ID mode
    unl; wr(11'h555, 16'h0090);
    rd(11'h000, {8'h00, MFR}, "R5 maker code"); rd(11'h001, {8'h00, DEV}, "R5 device code");
    rd(11'h002, 16'h0000, "R5 other offset");
    wr(11'h000, 16'h00F0);
    rd(11'h012, 16'h0A30, "R5 back to array");

    // R4 bypass
    unl; wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0); wr(11'h030, 16'hABCD);
    rd(11'h030, 16'h0000, "R8 status of bit7-set data");
    wait_idle;
    wr(11'h000, 16'h00A0); wr(11'h031, 16'h00FF); wait_idle;
    rd(11'h030, 16'hABCD, "R4 bypass word 1"); rd(11'h031, 16'h00FF, "R4 bypass word 2");
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0); wr(11'h032, 16'h0000);
    check("R4 no program after exit", {15'd0, busy}, 16'h0);
    rd(11'h032, 16'hFFFF, "R4 word untouched after exit");

    // R12 writes during busy
    unl; wr(11'h555, 16'h00A0); wr(11'h040, 16'h00F0);
    wr(11'h040, 16'h0000); unl;
    wait_idle;
    wr(11'h555, 16'h00A0); wr(11'h041, 16'h0000);
    check("R12 no leftover sequence", {15'd0, busy}, 16'h0);
    rd(11'h040, 16'h00F0, "R12 busy write ignored"); rd(11'h041, 16'hFFFF, "R12 word untouched");

    // R6 sector erase
    unl; wr(11'h555, 16'h00A0); wr(11'h210, 16'h0000); wait_idle;
    unl; wr(11'h555, 16'h00A0); wr(11'h410, 16'h0000); wait_idle;
    unl; wr(11'h555, 16'h00A0); wr(11'h610, 16'h0000); wait_idle;
    erase_lead; wr(11'h210, 16'h0030);
    rd(11'h210, 16'h0000, "R8 erase status");
    wait_idle;
    rd(11'h210, 16'hFFFF, "R6 sector 1 erased"); rd(11'h410, 16'h0000, "R6 sector 2 kept");
    rd(11'h012, 16'h0A30, "R6 sector 0 kept");
    erase_lead; wr(11'h400, 16'h0030); wr(11'h600, 16'h0030); wait_idle;
    rd(11'h410, 16'hFFFF, "R6 multi sector 2"); rd(11'h610, 16'hFFFF, "R6 multi sector 3");
    rd(11'h021, 16'h1234, "R6 sector 0 kept after multi");

    // R10 abort
    unl; wr(11'h555, 16'h00A0); wr(11'h050, 16'h0000);
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
    check("R10 busy dropped", {15'd0, busy}, 16'h0);
    rd(11'h050, 16'hFFFF, "R10 aborted word unchanged");
    unl; wr(11'h555, 16'h00A0); wr(11'h050, 16'h8001); wait_idle;
    rd(11'h050, 16'h8001, "R10 program after abort");

    repeat (4) @(negedge clk);
    check("R11 all reads answered", 16'(exp_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule